// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable, cycle-accurate model of a pipelined synchronous static RAM that needs no idle cycles between reads and writes. Address and control are registered on every active clock edge. The data for a command moves one cycle after the command is sampled. Write data is captured late, on the edge that closes the data cycle. Read data flows combinationally from the array during the data cycle, without an output register.

A two-bit burst sequencer lets a host load one starting address and then step through four words. The stepping order is either linear or interleaved.

The design has two whole-pipeline stalls: a clock-enable freeze and a sleep input. Either one makes the edge behave as if it never happened. Instead of a tri-state bus, the block exposes separate write-data, read-data and read-data-valid (drive enable) signals. The storage is a small parameterized array with one array per 9-bit byte lane.

Top module: `zt_sram`

## Requirements
- R1: On an active edge with `advance`=0 and the chip selected, the block captures `addr` and the command (`is_read`=1 read, 0 write). The read data of that command appears in the following cycle with `rdata_oe`=1.
- R2: For a write command, `wdata` is written into the array at the next active edge (late write). A read loaded on that same edge already returns the new data.
- R3: Bit i of `lane_wen_n` is active low and guards data bits [9i+8:9i]. It is sampled together with each load or burst beat, one cycle ahead of its data. It has no effect on the array during reads.
- R4: On an active edge with `advance`=1 inside a burst, the block ignores `addr` and repeats the burst's command. In linear order (`interleave`=0), the low two address bits step by +1 modulo 4 and the upper bits are kept. Beats after the fourth keep wrapping.
- R5: With `interleave`=1, the low two address bits of beat k are the starting low bits XOR k (k = 0..3, modulo 4).
- R6: A load edge while the chip is not selected starts a deselect. The block performs no operation in the next cycle, so `rdata_oe`=0, and the burst ends. Later `advance` edges do nothing until the next selected load.
- R7: The chip is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1.
- R8: While `freeze`=1, an edge changes no register and no array word, and the outputs hold.
- R9: While `sleep`=1, an edge changes no state, and stored data is kept.
- R10: `rdata_oe` is 1 only in the data cycle of a read with `out_en_n`=0. `out_en_n` acts without a clock. `rdata` is all zeros whenever `rdata_oe`=0.
- R11: A synchronous active-high `rst` clears the pipeline and any burst, leaving `rdata_oe`=0. After reset, advances are idle. The array contents survive reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| freeze | input | 1 | High: the edge is ignored (clock-enable stall) |
| sleep | input | 1 | High: internal clock gated, state kept |
| advance | input | 1 | 1 = step burst, 0 = load new command |
| is_read | input | 1 | Command type on load: 1 read, 0 write |
| sel_a_n | input | 1 | Active-low chip select |
| sel_b_n | input | 1 | Active-low chip select |
| sel_c | input | 1 | Active-high chip select |
| addr | input | ADDR_W | Word address, sampled on loads |
| lane_wen_n | input | LANES | Active-low per-lane write enables |
| interleave | input | 1 | Static burst order: 1 interleaved, 0 linear |
| out_en_n | input | 1 | Asynchronous active-low read output enable |
| wdata | input | LANES*LANE_W | Write data, captured one cycle after the command |
| rdata | output | LANES*LANE_W | Flow-through read data |
| rdata_oe | output | 1 | High when the block drives read data |

## Verification
The most delicate coincidence is a late write landing on the same edge that loads a read of the same word. The bench provokes it by issuing a write and then immediately a read of that address. It checks that the read's data cycle returns the freshly written word, while the partially enabled lanes keep their old contents. A second coincidence pairs a freeze with a pending write. The bench holds `freeze` high on the edge where the write data would land, drives junk on `wdata` and a conflicting load, and then releases the freeze. The word read back must match the data present on the unfrozen edge.

// File: rtl/zt_pkg.sv
package zt_pkg;

  // Low two address bits of beat number `beat` in a burst that began at `start`.
  function automatic logic [1:0] beat_low(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       ilv);
    return ilv ? (start ^ beat) : (start + beat);
  endfunction

endpackage

// File: rtl/zt_burst_seq.sv
module zt_burst_seq
  import zt_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              advance,
  input  logic              is_read,
  input  logic              selected,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  lane_n,
  input  logic              interleave,
  output logic              op_vld,
  output logic              op_wr,
  output logic [ADDR_W-1:0] op_addr,
  output logic [LANES-1:0]  op_lane_n
);

  localparam int HI_W = ADDR_W - 2;

  logic            act;
  logic            cmd_wr;
  logic [HI_W-1:0] base_hi;
  logic [1:0]      start_lo;
  logic [1:0]      beat;
  logic [1:0]      nxt_beat;

  assign nxt_beat = beat + 2'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b0;
      cmd_wr    <= 1'b0;
      base_hi   <= '0;
      start_lo  <= '0;
      beat      <= '0;
      op_vld    <= 1'b0;
      op_wr     <= 1'b0;
      op_addr   <= '0;
      op_lane_n <= '1;
    end else if (tick) begin
      if (!advance) begin
        if (selected) begin
          act       <= 1'b1;
          cmd_wr    <= !is_read;
          base_hi   <= addr[ADDR_W-1:2];
          start_lo  <= addr[1:0];
          beat      <= 2'd0;
          op_vld    <= 1'b1;
          op_wr     <= !is_read;
          op_addr   <= addr;
          op_lane_n <= lane_n;
        end else begin
          act    <= 1'b0;
          op_vld <= 1'b0;
          op_wr  <= 1'b0;
        end
      end else if (act) begin
        beat      <= nxt_beat;
        op_vld    <= 1'b1;
        op_wr     <= cmd_wr;
        op_addr   <= {base_hi, beat_low(start_lo, nxt_beat, interleave)};
        op_lane_n <= lane_n;
      end else begin
        op_vld <= 1'b0;
        op_wr  <= 1'b0;
      end
    end
  end

  assert_load_capture_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && !advance && selected) |=>
      (op_vld && op_addr == $past(addr) && op_wr == !$past(is_read)));

  assert_deselect_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !advance && !selected) |=> !op_vld);

  assert_idle_advance_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && advance && !act) |=> !op_vld);

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && advance && act && !interleave) |=>
      (op_addr[1:0] == $past(op_addr[1:0]) + 2'd1));

  assert_upper_kept_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && advance && act) |=>
      (op_addr[ADDR_W-1:2] == $past(op_addr[ADDR_W-1:2])));

  assert_freeze_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(op_vld) && $stable(op_wr) && $stable(op_addr)));

endmodule

// File: rtl/zt_lane_mem.sv
module zt_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [LANES-1:0]        wlane_n,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && !wlane_n[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/zt_read_gate.sv
module zt_read_gate #(
  parameter int DATA_W = 18
) (
  input  logic              op_vld,
  input  logic              op_wr,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_oe
);

  always_comb begin
    rdata_oe = op_vld && !op_wr && !out_en_n;
    rdata    = rdata_oe ? word : '0;
  end

endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    freeze,
  input  logic                    sleep,
  input  logic                    advance,
  input  logic                    is_read,
  input  logic                    sel_a_n,
  input  logic                    sel_b_n,
  input  logic                    sel_c,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        lane_wen_n,
  input  logic                    interleave,
  input  logic                    out_en_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_oe
);

  localparam int DATA_W = LANES * LANE_W;

  logic              tick;
  logic              selected;
  logic              op_vld;
  logic              op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [LANES-1:0]  op_lane_n;
  logic [DATA_W-1:0] word;
  logic              mem_we;

  assign tick     = !freeze && !sleep;
  assign selected = !sel_a_n && !sel_b_n && sel_c;
  assign mem_we   = tick && !rst && op_vld && op_wr;

  zt_burst_seq #(.ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .advance    (advance),
    .is_read    (is_read),
    .selected   (selected),
    .addr       (addr),
    .lane_n     (lane_wen_n),
    .interleave (interleave),
    .op_vld     (op_vld),
    .op_wr      (op_wr),
    .op_addr    (op_addr),
    .op_lane_n  (op_lane_n)
  );

  zt_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .wlane_n (op_lane_n),
    .waddr   (op_addr),
    .wdata   (wdata),
    .raddr   (op_addr),
    .rdata   (word)
  );

  zt_read_gate #(.DATA_W(DATA_W)) u_gate (
    .op_vld   (op_vld),
    .op_wr    (op_wr),
    .out_en_n (out_en_n),
    .word     (word),
    .rdata    (rdata),
    .rdata_oe (rdata_oe)
  );

  assert_deselect_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (tick && !advance && !selected) |=> !rdata_oe);

  assert_sleep_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (sleep && !freeze) |=> ($stable(rdata_oe) || $changed(out_en_n)));

endmodule

// File: tb/zt_sram_tb.sv
`timescale 1ns/1ps
module zt_sram_tb;

  typedef struct packed {
    logic        adv;
    logic        rd;
    logic        sel;
    logic [5:0]  addr;
    logic [1:0]  ln;
    logic [17:0] wd;
    logic        eoe;
    logic [17:0] erd;
  } row_t;

  localparam int NROWS = 17;
  localparam row_t TBL [NROWS] = '{
    '{1'b0, 1'b0, 1'b1, 6'h04, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 6'h3F, 2'b00, 18'h11111, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 6'h00, 2'b00, 18'h22222, 1'b0, 18'h00000},
    '{1'b1, 1'b0, 1'b1, 6'h00, 2'b00, 18'h33333, 1'b0, 18'h00000},
    '{1'b0, 1'b1, 1'b1, 6'h05, 2'b00, 18'h04444, 1'b1, 18'h22222},
    '{1'b1, 1'b1, 1'b1, 6'h00, 2'b11, 18'h00000, 1'b1, 18'h33333},
    '{1'b1, 1'b1, 1'b1, 6'h00, 2'b11, 18'h00000, 1'b1, 18'h04444},
    '{1'b1, 1'b1, 1'b1, 6'h00, 2'b11, 18'h00000, 1'b1, 18'h11111},
    '{1'b1, 1'b1, 1'b1, 6'h00, 2'b11, 18'h00000, 1'b1, 18'h22222},
    '{1'b0, 1'b1, 1'b0, 6'h05, 2'b11, 18'h00000, 1'b0, 18'h00000},
    '{1'b1, 1'b1, 1'b1, 6'h05, 2'b11, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, 1'b0, 1'b1, 6'h08, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, 1'b0, 1'b1, 6'h08, 2'b01, 18'h0AAAA, 1'b0, 18'h00000},
    '{1'b0, 1'b1, 1'b1, 6'h08, 2'b00, 18'h3FE00, 1'b1, 18'h3FEAA},
    '{1'b0, 1'b0, 1'b1, 6'h09, 2'b00, 18'h00000, 1'b0, 18'h00000},
    '{1'b0, 1'b1, 1'b1, 6'h09, 2'b00, 18'h12345, 1'b1, 18'h12345},
    '{1'b0, 1'b1, 1'b0, 6'h00, 2'b00, 18'h00000, 1'b0, 18'h00000}
  };

  logic        clk = 1'b0;
  logic        rst, freeze, sleep, advance, is_read;
  logic        sel_a_n, sel_b_n, sel_c, interleave, out_en_n;
  logic [5:0]  addr;
  logic [1:0]  lane_wen_n;
  logic [17:0] wdata, rdata;
  logic        rdata_oe;
  int          checks = 0;
  int          fails  = 0;
  logic        done   = 1'b0;

  always #5 clk = ~clk;

  zt_sram u_dut (
    .clk(clk), .rst(rst), .freeze(freeze), .sleep(sleep), .advance(advance),
    .is_read(is_read), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
    .addr(addr), .lane_wen_n(lane_wen_n), .interleave(interleave),
    .out_en_n(out_en_n), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input string tag, input logic eoe, input logic [17:0] erd);
    logic [18:0] exp_v, act_v;
    exp_v = {eoe, eoe ? erd : 18'h0};
    act_v = {rdata_oe, rdata};
    checks++;
    if (act_v !== exp_v) begin
      fails++;
      $display("FAIL %s actual oe=%0b data=%h expected oe=%0b data=%h",
               tag, act_v[18], act_v[17:0], exp_v[18], exp_v[17:0]);
    end
  endtask

  task automatic drive(input logic adv, input logic rd, input logic [5:0] a,
                       input logic [1:0] ln, input logic [17:0] wd);
    advance = adv; is_read = rd; addr = a; lane_wen_n = ln; wdata = wd;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic sel_all(input logic on);
    sel_a_n = !on; sel_b_n = !on; sel_c = on;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; freeze = 1'b0; sleep = 1'b0; interleave = 1'b0; out_en_n = 1'b0;
    sel_all(1'b1);
    drive(1'b1, 1'b1, 6'h0, 2'b11, 18'h0);
    cyc(); cyc();
    check("R11 reset state", 1'b0, 18'h0);
    rst = 1'b0;

    // Vector table: R1 load, R2 late write, R4 linear burst and wrap, R6 deselect, R3 lanes
    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i].adv, TBL[i].rd, TBL[i].addr, TBL[i].ln, TBL[i].wd);
      sel_all(TBL[i].sel);
      cyc();
      check($sformatf("R1/R2/R3/R4/R6 row %0d", i), TBL[i].eoe, TBL[i].erd);
    end
    sel_all(1'b1);

    // R10: asynchronous output enable
    drive(1'b0, 1'b1, 6'h09, 2'b11, 18'h0); cyc();
    check("R10 read visible", 1'b1, 18'h12345);
    out_en_n = 1'b1; #1;
    check("R10 oe high forces off", 1'b0, 18'h0);
    out_en_n = 1'b0; #1;
    check("R10 oe low restores", 1'b1, 18'h12345);

    // R3: lane enables ignored on reads
    drive(1'b0, 1'b1, 6'h09, 2'b00, 18'h3FFFF); cyc();
    check("R3 read with lanes on", 1'b1, 18'h12345);
    drive(1'b0, 1'b1, 6'h09, 2'b00, 18'h3FFFF); cyc();
    check("R3 word unchanged", 1'b1, 18'h12345);

    // R8: freeze holds read beat, then a pending write
    drive(1'b0, 1'b1, 6'h04, 2'b11, 18'h0); cyc();
    check("R8 before freeze", 1'b1, 18'h11111);
    freeze = 1'b1; drive(1'b1, 1'b1, 6'h00, 2'b11, 18'h0); cyc();
    check("R8 frozen advance", 1'b1, 18'h11111);
    freeze = 1'b0; cyc();
    check("R8 resumed advance", 1'b1, 18'h22222);
    drive(1'b0, 1'b0, 6'h04, 2'b00, 18'h0); cyc();
    check("R8 write issued", 1'b0, 18'h0);
    freeze = 1'b1; drive(1'b0, 1'b1, 6'h07, 2'b00, 18'h3FFFF); cyc();
    check("R8 write held", 1'b0, 18'h0);
    freeze = 1'b0; drive(1'b0, 1'b1, 6'h04, 2'b11, 18'h00777); cyc();
    check("R8 R2 write after release", 1'b1, 18'h00777);

    // R9: sleep
    sleep = 1'b1; drive(1'b0, 1'b1, 6'h06, 2'b11, 18'h0); cyc();
    check("R9 sleep ignores load", 1'b1, 18'h00777);
    sleep = 1'b0; cyc();
    check("R9 wake", 1'b1, 18'h33333);

    // R7: each enable alone deselects
    sel_b_n = 1'b1; cyc(); check("R7 second low enable", 1'b0, 18'h0);
    sel_all(1'b1); sel_c = 1'b0; cyc(); check("R7 high enable", 1'b0, 18'h0);
    sel_all(1'b1); sel_a_n = 1'b1; cyc(); check("R7 first low enable", 1'b0, 18'h0);
    sel_all(1'b1); cyc(); check("R7 all true", 1'b1, 18'h33333);

    // R5: interleaved from low bits 01 -> 5,4,7,6
    interleave = 1'b1;
    drive(1'b0, 1'b1, 6'h05, 2'b11, 18'h0); cyc();
    check("R5 beat0", 1'b1, 18'h22222);
    drive(1'b1, 1'b1, 6'h00, 2'b11, 18'h0); cyc();
    check("R5 beat1", 1'b1, 18'h00777);
    cyc(); check("R5 beat2", 1'b1, 18'h04444);
    cyc(); check("R5 beat3", 1'b1, 18'h33333);
    interleave = 1'b0;

    // R11: reset mid-burst
    drive(1'b0, 1'b1, 6'h05, 2'b11, 18'h0); cyc();
    check("R11 before reset", 1'b1, 18'h22222);
    rst = 1'b1; drive(1'b1, 1'b1, 6'h00, 2'b11, 18'h0); cyc();
    check("R11 in reset", 1'b0, 18'h0);
    rst = 1'b0; cyc();
    check("R11 advance idle after reset", 1'b0, 18'h0);
    drive(1'b0, 1'b1, 6'h05, 2'b11, 18'h0); cyc();
    check("R11 memory kept", 1'b1, 18'h22222);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule